// File: doc/BRIEF.md
# Power-of-Two PWM Clock Prescaler

This block derives a clock-enable tick for a PWM counter from the fast system clock. The counter advances only on cycles where `tick_o` is high, so no new clock net is created. A 3-bit ratio code picks a divide ratio of 2, 4, 8, 16, 32 or 64. Codes 5, 6 and 7 all saturate at 64. A separate enable bit either applies the divider or bypasses it. When the divider is bypassed, `tick_o` is high on every cycle.

Both configuration inputs are captured into an internal register on every rising edge. After reset that register holds "divider off, code 7", so switching the divider on without changing the code gives ratio 64. A 6-bit counter runs freely and fires the tick when the low bits that the ratio selects are all ones. Any change to the captured configuration clears the counter, so the first tick under the new setting comes one full period later.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain control or status level. `tick_o` is a status output with no back-pressure, and the consumer must act on each tick in the cycle it is high.

Top module: `pwm_clk_prescaler`

## Requirements
- R1: While `rst_i` is high and after its release, the captured configuration is "divider off, code 7". With `use_div_i`=0 and `ratio_code_i`=7 held, `tick_o` reads 1 on every cycle.
- R2: While the captured enable bit is 0, `tick_o` is 1 on every cycle, whatever the ratio code and whatever changes the code goes through.
- R3: With the divider on and code n in 0..4, the ratio is N = 2^(n+1). Let k count the cycles since the last restart, with k=0 in the first cycle after the capturing edge. `tick_o` is 1 exactly when k mod N equals N-1.
- R4: Codes 5, 6 and 7 each give ratio 64 under the same phase rule as R3.
- R5: With a 16 MHz system clock, codes 0, 2, 3 and 7 give tick rates of 8 MHz, 2 MHz, 1 MHz and 250 kHz. This means one tick every 2, 8, 16 and 64 cycles.
- R6: A change of `ratio_code_i` or `use_div_i` restarts the counter at the capturing edge, so the next tick comes a full new period later. The new setting governs `tick_o` from the cycle after that edge.
- R7: With the divider on, `tick_o` is never high in two consecutive cycles unless the configuration changes between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| use_div_i | input | 1 | 1 applies the divider, 0 bypasses it |
| ratio_code_i | input | 3 | Ratio code; N = 2^(min(code,5)+1) |
| tick_o | output | 1 | Clock-enable tick for the PWM counter |

## Verification
Every result of this block is due one rising edge after the inputs are presented. That edge captures the configuration and clears or advances the counter, and `tick_o` is a combinational function of those registers. The driver sets the inputs after a falling edge and queues the expected tick for the cycle after the next rising edge. The monitor samples 2 ns after that rising edge. The expected value comes from a cycle index k held in the bench, which restarts at each configuration change or reset. A tick is expected when k mod N equals N-1, which places the first tick of every new setting N cycles after the capturing edge.

// File: rtl/pwm_prescale_pkg.sv
package pwm_prescale_pkg;

  localparam int PS_CODE_W    = 3;
  localparam int PS_MAX_SHIFT = 6;
  localparam logic [PS_CODE_W-1:0] PS_CODE_RESET = '1;

  typedef struct packed {
    logic                 use_div;
    logic [PS_CODE_W-1:0] code;
  } ps_cfg_t;

  localparam ps_cfg_t PS_CFG_RESET = '{use_div: 1'b0, code: PS_CODE_RESET};

endpackage

// File: rtl/ps_cfg_track.sv
module ps_cfg_track
  import pwm_prescale_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 use_div_i,
  input  logic [PS_CODE_W-1:0] code_i,
  output ps_cfg_t              cfg_q,
  output logic                 restart_o
);

  ps_cfg_t cfg_d;

  always_comb begin
    cfg_d.use_div = use_div_i;
    cfg_d.code    = code_i;
  end

  // Restart whenever the presented setting differs from the captured one.
  assign restart_o = (cfg_d != cfg_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) cfg_q <= PS_CFG_RESET;
    else       cfg_q <= cfg_d;
  end

  // R1: the captured setting is the reset value in the cycle after reset
  assert_cfg_reset_R1: assert property (@(posedge clk_i)
    rst_i |=> (cfg_q == PS_CFG_RESET));

  // R6: after a cycle without reset, the captured setting is the one presented then
  assert_cfg_capture_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (cfg_q.code == $past(code_i)) && (cfg_q.use_div == $past(use_div_i)));

endmodule

// File: rtl/ps_ratio_decode.sv
module ps_ratio_decode
  import pwm_prescale_pkg::*;
#(
  parameter int MAX_SHIFT = PS_MAX_SHIFT
)(
  input  logic [PS_CODE_W-1:0] code_i,
  output logic [MAX_SHIFT-1:0] mask_o
);

  // Bit b of the mask is set when the code reaches b; this gives 2^(code+1)
  // as the ratio, and saturates once every bit is set.
  for (genvar b = 0; b < MAX_SHIFT; b++) begin : g_mask
    assign mask_o[b] = (int'(code_i) >= b);
  end

  always_comb begin
    // R4: saturating codes select every counter bit
    if (int'(code_i) >= MAX_SHIFT - 1)
      assert_sat_mask_R4: assert (&mask_o);
    // R3: the mask width tracks the code below saturation
    else
      assert_mask_width_R3: assert ($countones(mask_o) == int'(code_i) + 1);
  end

endmodule

// File: rtl/ps_counter.sv
module ps_counter #(
  parameter int CNT_W = 6
)(
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] mask_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  // Hit when every selected low bit is one.
  assign hit_o = &(cnt_q | ~mask_i);

  // R6: a restart leaves the counter at zero
  assert_restart_clears_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> (cnt_q == '0));

  // R3: the counter steps by one without a restart
  assert_count_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!restart_i && !$past(rst_i)) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pwm_clk_prescaler.sv
module pwm_clk_prescaler
  import pwm_prescale_pkg::*;
#(
  parameter int MAX_SHIFT = PS_MAX_SHIFT
)(
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 use_div_i,
  input  logic [PS_CODE_W-1:0] ratio_code_i,
  output logic                 tick_o
);

  ps_cfg_t              cfg_q;
  logic                 restart;
  logic [MAX_SHIFT-1:0] mask;
  logic                 hit;

  ps_cfg_track u_cfg (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .use_div_i (use_div_i),
    .code_i    (ratio_code_i),
    .cfg_q     (cfg_q),
    .restart_o (restart)
  );

  ps_ratio_decode #(.MAX_SHIFT(MAX_SHIFT)) u_dec (
    .code_i (cfg_q.code),
    .mask_o (mask)
  );

  ps_counter #(.CNT_W(MAX_SHIFT)) u_cnt (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (restart),
    .mask_i    (mask),
    .hit_o     (hit)
  );

  assign tick_o = cfg_q.use_div ? hit : 1'b1;

  // R2: bypass captured in the previous cycle keeps the tick high
  assert_bypass_high_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !use_div_i |=> tick_o);

  // R7: no back-to-back ticks while dividing with a steady setting
  assert_single_tick_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_o && cfg_q.use_div && !restart) |=> !tick_o);

  // R6: the cycle after a restart into divided mode carries no tick
  assert_restart_gap_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (restart && use_div_i) |=> !tick_o);

endmodule

// File: tb/pwm_clk_prescaler_test.sv
module pwm_clk_prescaler_test;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       use_div = 1'b0;
  logic [2:0] code = 3'd7;
  logic       tick;

  item_t q[$];
  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;

  int         m_k = 0;
  logic       m_use = 1'b0;
  logic [2:0] m_code = 3'd7;

  always #4 clk = ~clk;

  pwm_clk_prescaler uut (
    .clk_i        (clk),
    .rst_i        (rst),
    .use_div_i    (use_div),
    .ratio_code_i (code),
    .tick_o       (tick)
  );

  // Driver: present inputs after a falling edge, queue the tick due after the next rise.
  task automatic step(input logic u, input logic [2:0] c, input logic r, input string req);
    item_t it;
    int n;
    @(negedge clk);
    rst = r;
    use_div = u;
    code = c;
    if (r) begin
      m_use = 1'b0; m_code = 3'd7; m_k = 0;
    end else if (u != m_use || c != m_code) begin
      m_use = u; m_code = c; m_k = 0;
    end else begin
      m_k++;
    end
    n = 1 << (((m_code > 3'd5) ? 5 : int'(m_code)) + 1);
    it.exp = m_use ? ((m_k % n) == n - 1) : 1'b1;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic run(input logic u, input logic [2:0] c, input int cycles, input string req);
    for (int i = 0; i < cycles; i++) step(u, c, 1'b0, req);
  endtask

  // Monitor: sample 2 ns after each rising edge and compare.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (tick !== it.exp) begin
        errors++;
        $display("FAIL %s: tick actual=%b expected=%b at %0t", it.req, tick, it.exp, $time);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1'b0, 3'd7, 1'b1, "R1");
    run(1'b0, 3'd7, 6, "R1");
    // R2: bypass under every code
    for (int c = 0; c < 8; c++) run(1'b0, 3'(c), 3, "R2");
    run(1'b0, 3'd7, 2, "R2");
    // R5: default code with divider on gives ratio 64
    run(1'b1, 3'd7, 140, "R5");
    run(1'b1, 3'd0, 20, "R5");
    run(1'b1, 3'd2, 40, "R5");
    run(1'b1, 3'd3, 50, "R5");
    // R3: remaining low codes
    run(1'b1, 3'd1, 20, "R3");
    run(1'b1, 3'd4, 70, "R3");
    // R4: saturating codes
    run(1'b1, 3'd5, 130, "R4");
    run(1'b1, 3'd6, 130, "R4");
    // R6: restart mid-period by code change and by enable toggle
    run(1'b1, 3'd3, 10, "R6");
    run(1'b1, 3'd2, 20, "R6");
    run(1'b0, 3'd2, 3, "R6");
    run(1'b1, 3'd2, 20, "R6");
    // R7: fastest ratio alternates without back-to-back ticks
    run(1'b1, 3'd0, 16, "R7");
    // R1: reset mid-run returns to bypass and code 7
    for (int i = 0; i < 2; i++) step(1'b1, 3'd1, 1'b1, "R1");
    run(1'b0, 3'd7, 4, "R1");
    run(1'b1, 3'd7, 70, "R5");
    @(posedge clk);
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule